// File: doc/BRIEF.md
# Operand Forwarding Unit

This block decides where each of the two ALU operands of a five-stage in-order pipeline comes from, and then selects that value. An instruction in the execute stage can depend on a result that an earlier instruction has computed but not yet written to the register file. The block compares the two source register indices of that instruction with the destination indices of the two instructions ahead of it: the one in the memory stage, which holds an ALU result, and the one in the writeback stage, which holds either load data or an older ALU result. For each operand it returns a 2-bit source code and the operand value picked by that code.

It is purely combinational. The codes and operands follow the pipeline-register fields within the same cycle. Register 0 is hardwired to zero, so it is never a forwarding target. When both later stages write the same register, the newer result, in the memory stage, wins. A dependency three or more instructions back is left to the register file, which writes in the first half of a cycle and reads in the second half. Stall generation, load-use detection and branch hazards belong to other blocks.

There is no state machine. Each operand lane is one priority decision with three outcomes: register file (no hit), writeback stage (older hit) and memory stage (newest hit).

Top module: `opnd_fwd_unit`

## Requirements
- R1: When neither later stage writes an operand's source register, that operand's code is 00 and the operand equals its register-file read value.
- R2: When the memory-stage write enable is 1, its destination is nonzero and it equals the operand's source index, the code is 10 and the operand equals the memory-stage ALU result.
- R3: When only the writeback stage matches (write enable 1, nonzero destination equal to the source index), the code is 01 and the operand equals the writeback value.
- R4: When both stages match the same operand, the code is 10 and the memory-stage result is used.
- R5: A destination index of 0 never causes forwarding, even with its write enable at 1. Code 00 results.
- R6: A stage whose write enable is 0 never causes forwarding, whatever its destination index.
- R7: Operands A and B are resolved independently. In one cycle A may take one stage and B the other.
- R8: Code 11 is never produced. A code of 11 at an operand selector yields the register-file value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | 5 | First source register index of the instruction in execute |
| src_b_idx | input | 5 | Second source register index of the instruction in execute |
| ex_dst_idx | input | 5 | Destination index of the instruction in the memory stage |
| ex_dst_we | input | 1 | Register write enable of the instruction in the memory stage |
| wb_dst_idx | input | 5 | Destination index of the instruction in the writeback stage |
| wb_dst_we | input | 1 | Register write enable of the instruction in the writeback stage |
| rf_rd_a | input | 32 | Register-file value latched for operand A |
| rf_rd_b | input | 32 | Register-file value latched for operand B |
| ex_result | input | 32 | ALU result held in the memory stage |
| wb_value | input | 32 | Value being written back (load data or older ALU result) |
| sel_a | output | 2 | Source code for operand A: 00 register file, 10 memory stage, 01 writeback |
| sel_b | output | 2 | Source code for operand B, same encoding |
| opnd_a | output | 32 | Selected ALU operand A |
| opnd_b | output | 32 | Selected ALU operand B |

## Verification
The patterns are chosen so that each one separates two outcomes that a faulty lane could confuse. A vector with unrelated destinations separates forwarding from pass-through. Single hits in the memory stage and in the writeback stage, on each operand, show that each code picks its own data word. A double hit tests the priority, because only the newer value is correct. Vectors with a zero destination or a cleared write enable, each with otherwise matching indices, show that these guards block forwarding. Crossed vectors, where A hits one stage and B hits the other, and the reverse, show that the two lanes do not share a decision. The same vectors also check the highest register index.

// File: rtl/opnd_fwd_pkg.sv
package opnd_fwd_pkg;

    // Operand source codes; the pipeline decodes these bit patterns
    typedef enum logic [1:0] {
        SEL_REGFILE  = 2'b00,
        SEL_WB_STAGE = 2'b01,
        SEL_EX_STAGE = 2'b10
    } opnd_sel_e;

endpackage

// File: rtl/opnd_fwd_detect.sv
module opnd_fwd_detect
    import opnd_fwd_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] src_idx,
    input  logic [IDX_W-1:0] ex_dst_idx,
    input  logic             ex_dst_we,
    input  logic [IDX_W-1:0] wb_dst_idx,
    input  logic             wb_dst_we,
    output opnd_sel_e        sel
);

    logic ex_hit;
    logic wb_hit;

    always_comb begin
        ex_hit = ex_dst_we && (ex_dst_idx != '0) && (ex_dst_idx == src_idx);
        wb_hit = wb_dst_we && (wb_dst_idx != '0) && (wb_dst_idx == src_idx);
    end

    // Newer result first
    always_comb begin
        if (ex_hit) begin
            sel = SEL_EX_STAGE;
        end else if (wb_hit) begin
            sel = SEL_WB_STAGE;
        end else begin
            sel = SEL_REGFILE;
        end
    end

    always_comb begin
        if (src_idx == '0) begin
            AST_ZERO_NEVER_FORWARDS: assert (sel == SEL_REGFILE) else $error("zero index forwarded"); // R5
        end
        if (!ex_dst_we && !wb_dst_we) begin
            AST_NO_WRITE_NO_FORWARD: assert (sel == SEL_REGFILE) else $error("forward without write"); // R6
        end
        if (!ex_dst_we) begin
            AST_EX_NEEDS_WRITE: assert (sel != SEL_EX_STAGE) else $error("ex path without write"); // R6
        end
    end

endmodule

// File: rtl/opnd_fwd_mux.sv
module opnd_fwd_mux
    import opnd_fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] ex_val,
    input  logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] y
);

    always_comb begin
        case (sel)
            SEL_EX_STAGE: y = ex_val;
            SEL_WB_STAGE: y = wb_val;
            default:      y = rf_val;   // 00 and the unused 11
        endcase
    end

endmodule

// File: rtl/opnd_fwd_unit.sv
module opnd_fwd_unit
    import opnd_fwd_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic [IDX_W-1:0]  src_a_idx,
    input  logic [IDX_W-1:0]  src_b_idx,
    input  logic [IDX_W-1:0]  ex_dst_idx,
    input  logic              ex_dst_we,
    input  logic [IDX_W-1:0]  wb_dst_idx,
    input  logic              wb_dst_we,
    input  logic [DATA_W-1:0] rf_rd_a,
    input  logic [DATA_W-1:0] rf_rd_b,
    input  logic [DATA_W-1:0] ex_result,
    input  logic [DATA_W-1:0] wb_value,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);

    localparam int NUM_OPND = 2;

    logic [IDX_W-1:0]  lane_src [NUM_OPND];
    logic [DATA_W-1:0] lane_rf  [NUM_OPND];
    opnd_sel_e         lane_sel [NUM_OPND];
    logic [DATA_W-1:0] lane_y   [NUM_OPND];

    assign lane_src[0] = src_a_idx;
    assign lane_src[1] = src_b_idx;
    assign lane_rf[0]  = rf_rd_a;
    assign lane_rf[1]  = rf_rd_b;

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_lane
        opnd_fwd_detect #(
            .IDX_W (IDX_W)
        ) detect_i (
            .src_idx    (lane_src[g]),
            .ex_dst_idx (ex_dst_idx),
            .ex_dst_we  (ex_dst_we),
            .wb_dst_idx (wb_dst_idx),
            .wb_dst_we  (wb_dst_we),
            .sel        (lane_sel[g])
        );

        opnd_fwd_mux #(
            .DATA_W (DATA_W)
        ) mux_i (
            .sel    (lane_sel[g]),
            .rf_val (lane_rf[g]),
            .ex_val (ex_result),
            .wb_val (wb_value),
            .y      (lane_y[g])
        );

        // Decision from the detector against the word picked by the mux
        always_comb begin
            AST_SEL_NEVER_ELEVEN: assert (lane_sel[g] != 2'b11) else $error("illegal code"); // R8
            if (lane_sel[g] == SEL_EX_STAGE) begin
                AST_EX_PATH_DATA: assert (lane_y[g] == ex_result) else $error("ex data"); // R2
            end
            if (lane_sel[g] == SEL_WB_STAGE) begin
                AST_WB_PATH_DATA: assert (lane_y[g] == wb_value) else $error("wb data"); // R3
            end
            if (lane_sel[g] == SEL_REGFILE) begin
                AST_RF_PATH_DATA: assert (lane_y[g] == lane_rf[g]) else $error("rf data"); // R1
            end
            if (ex_dst_we && (ex_dst_idx != '0) && (ex_dst_idx == lane_src[g])
                && wb_dst_we && (wb_dst_idx == ex_dst_idx)) begin
                AST_EX_WINS_DOUBLE: assert (lane_y[g] == ex_result) else $error("priority"); // R4
            end
        end
    end

    assign sel_a  = lane_sel[0];
    assign sel_b  = lane_sel[1];
    assign opnd_a = lane_y[0];
    assign opnd_b = lane_y[1];

endmodule

// File: tb/opnd_fwd_unit_tb.sv
module opnd_fwd_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 5;
    localparam int DATA_W     = 32;

    localparam logic [DATA_W-1:0] RF_A = 32'hAAAA_0001;
    localparam logic [DATA_W-1:0] RF_B = 32'hBBBB_0002;
    localparam logic [DATA_W-1:0] EXV  = 32'h0000_0008;
    localparam logic [DATA_W-1:0] WBV  = 32'hDEAD_0005;

    typedef struct {
        logic [1:0]        sel_a;
        logic [1:0]        sel_b;
        logic [DATA_W-1:0] opnd_a;
        logic [DATA_W-1:0] opnd_b;
        string             tag;
    } exp_item_t;

    logic clk;
    logic rst_n;

    logic [IDX_W-1:0]  src_a_idx, src_b_idx, ex_dst_idx, wb_dst_idx;
    logic              ex_dst_we, wb_dst_we;
    logic [DATA_W-1:0] rf_rd_a, rf_rd_b, ex_result, wb_value;
    logic [1:0]        sel_a, sel_b;
    logic [DATA_W-1:0] opnd_a, opnd_b;

    exp_item_t exp_q [$];
    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    opnd_fwd_unit #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) dut_i (
        .src_a_idx  (src_a_idx),
        .src_b_idx  (src_b_idx),
        .ex_dst_idx (ex_dst_idx),
        .ex_dst_we  (ex_dst_we),
        .wb_dst_idx (wb_dst_idx),
        .wb_dst_we  (wb_dst_we),
        .rf_rd_a    (rf_rd_a),
        .rf_rd_b    (rf_rd_b),
        .ex_result  (ex_result),
        .wb_value   (wb_value),
        .sel_a      (sel_a),
        .sel_b      (sel_b),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(string what, string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one vector on the falling edge and queue its expectation
    task automatic drive(input logic [4:0] sa, input logic [4:0] sb,
                         input logic [4:0] ed, input logic ew,
                         input logic [4:0] wd, input logic ww,
                         input logic [1:0] ea, input logic [1:0] eb, input string tag);
        exp_item_t it;
        @(negedge clk);
        src_a_idx  = sa;
        src_b_idx  = sb;
        ex_dst_idx = ed;
        ex_dst_we  = ew;
        wb_dst_idx = wd;
        wb_dst_we  = ww;
        it.sel_a  = ea;
        it.sel_b  = eb;
        it.opnd_a = (ea == 2'b10) ? EXV : (ea == 2'b01) ? WBV : RF_A;
        it.opnd_b = (eb == 2'b10) ? EXV : (eb == 2'b01) ? WBV : RF_B;
        it.tag    = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: results are combinational, so they are settled half a cycle later
    always @(posedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            exp_item_t it;
            it = exp_q.pop_front();
            check("sel_a", it.tag, {30'd0, sel_a}, {30'd0, it.sel_a});
            check("sel_b", it.tag, {30'd0, sel_b}, {30'd0, it.sel_b});
            check("opnd_a", it.tag, opnd_a, it.opnd_a);
            check("opnd_b", it.tag, opnd_b, it.opnd_b);
            check("sel_a_not_11 R8", it.tag, {31'd0, sel_a == 2'b11}, 32'd0);
            check("sel_b_not_11 R8", it.tag, {31'd0, sel_b == 2'b11}, 32'd0);
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n      = 1'b0;
        src_a_idx  = '0;
        src_b_idx  = '0;
        ex_dst_idx = '0;
        ex_dst_we  = 1'b0;
        wb_dst_idx = '0;
        wb_dst_we  = 1'b0;
        rf_rd_a    = RF_A;
        rf_rd_b    = RF_B;
        ex_result  = EXV;
        wb_value   = WBV;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Reset state: all indices zero, nothing forwarded (R1)
        drive(5'd0,  5'd0,  5'd0,  1'b0, 5'd0,  1'b0, 2'b00, 2'b00, "R1 reset state");
        drive(5'd3,  5'd4,  5'd5,  1'b1, 5'd6,  1'b1, 2'b00, 2'b00, "R1 no dependency");
        drive(5'd2,  5'd7,  5'd2,  1'b1, 5'd9,  1'b1, 2'b10, 2'b00, "R2 ex hit on A");
        drive(5'd7,  5'd2,  5'd2,  1'b1, 5'd9,  1'b1, 2'b00, 2'b10, "R2 ex hit on B");
        drive(5'd2,  5'd3,  5'd5,  1'b1, 5'd2,  1'b1, 2'b01, 2'b00, "R3 wb hit on A");
        drive(5'd31, 5'd31, 5'd30, 1'b1, 5'd31, 1'b1, 2'b01, 2'b01, "R3 wb hit index 31");
        drive(5'd2,  5'd2,  5'd2,  1'b1, 5'd2,  1'b1, 2'b10, 2'b10, "R4 double hit");
        drive(5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00, "R5 zero destination");
        drive(5'd2,  5'd2,  5'd2,  1'b0, 5'd2,  1'b0, 2'b00, 2'b00, "R6 write enables clear");
        drive(5'd2,  5'd2,  5'd2,  1'b0, 5'd2,  1'b1, 2'b01, 2'b01, "R6 ex enable clear");
        drive(5'd4,  5'd9,  5'd4,  1'b1, 5'd9,  1'b1, 2'b10, 2'b01, "R7 A ex B wb");
        drive(5'd9,  5'd4,  5'd4,  1'b1, 5'd9,  1'b1, 2'b01, 2'b10, "R7 A wb B ex");

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule